// File: doc/BRIEF.md
# Serial Shift Interface Unit

This block is a byte-wide serial shift unit with a small register front end. One shared data register carries the outgoing byte: software loads it before a transfer, the serial clock shifts it out most-significant bit first, and the received bits fill it from the low end. When the transfer is over, the same register holds the byte that came in. A small edge counter advances on every edge of the serial clock. When it wraps, a sticky completion flag is set. Software polls this flag and clears it by writing a one.

The unit works as a slave. Its serial clock comes from an external pin, and the shift edge can be set to rising or falling. A mode bit picks one of two physical layers. The three-wire layer has a push-pull data output and a separate data input. The two-wire layer has an open-drain data line, and in this layer the unit can also pull the clock line low to insert wait states. All pins are brought into the system clock domain through a two-flop synchronizer, and the clock edges are detected there.

Register map (`reg_addr_i`):
- 0: control. Bit 0 selects the two-wire layer. Bits 2:1 select the shift edge: 01 is rising, 10 is falling, and 00 or 11 is off.
- 1: status. Bit 7 is the completion flag. Bits 3:0 are the edge count.
- 2: data.

Top module: `ssu_top`

## Requirements
- R1: After reset, the control, status and data registers all read 0, and `so_o`, `sda_oe_o` and `scl_oe_o` are all 0.
- R2: The control register stores bit 0 (1 selects the two-wire layer) and bits 2:1 (the shift-edge select). It reads back those bits and reads zero in bits 7:3.
- R3: On each selected shift edge of `ser_clk_i`, the data register shifts left by one bit. The new bit 0 comes from `sdi_i` in three-wire mode and from `sda_i` in two-wire mode. `so_o` follows bit 7 of the data register.
- R4: While the shift-edge select is 01 or 10, every rising and every falling edge of `ser_clk_i` adds one to the 4-bit count. While the select is 00, edges change neither the count nor the data register.
- R5: The edge that takes the count from 15 to 0 sets the completion flag (status bit 7). After 16 edges, the data register holds the 8 bits received, first bit in bit 7.
- R6: A write to the status register loads the count from bits 3:0. It clears the flag when bit 7 is 1 and leaves the flag unchanged when bit 7 is 0.
- R7: A write to the data register loads the byte. The new bit 7 appears on `so_o`.
- R8: `sda_oe_o` (pull the data line low) is 1 exactly when two-wire mode is selected and data bit 7 is 0. It is always 0 in three-wire mode.
- R9: In two-wire mode, a falling edge of `ser_clk_i` that arrives while the flag is already set raises `scl_oe_o` (hold the clock line low). `scl_oe_o` drops when the flag is cleared and never rises in three-wire mode.
- R10: `reg_rdata_o` shows the register at `reg_addr_i` one clock after that address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered read data |
| ser_clk_i | input | 1 | External serial clock pin |
| sdi_i | input | 1 | Three-wire serial data input |
| sda_i | input | 1 | Two-wire data line level |
| so_o | output | 1 | Three-wire serial data output |
| sda_oe_o | output | 1 | Pull two-wire data line low |
| scl_oe_o | output | 1 | Pull two-wire clock line low (wait state) |

## Verification
A change on a pin reaches the data register and the counter on the third system clock edge after the change: two synchronizer stages, then the register. The pin outputs follow one edge later, and register reads return one edge after the address is set. The bench drives every pin change and bus cycle at the falling clock edge. It then waits five full cycles before it applies the next change or samples anything, so each result is read well after it has settled and before the next stimulus. Register reads present the address and sample `reg_rdata_o` one falling edge later.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  typedef enum logic [1:0] {
    CS_OFF  = 2'b00,
    CS_RISE = 2'b01,
    CS_FALL = 2'b10,
    CS_RSV  = 2'b11
  } clk_sel_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
endpackage

// File: rtl/ssu_sync.sv
module ssu_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         clk_pin_i,
  input  logic [W-1:0] data_pin_i,
  output logic [W-1:0] data_sync_o,
  output logic         clk_rise_o,
  output logic         clk_fall_o
);
  localparam int TW = W + 1;

  logic [TW-1:0] stage_q [STAGES];
  logic          clk_prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[g] <= '0;
        else if (g == 0) stage_q[g] <= {data_pin_i, clk_pin_i};
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) clk_prev_q <= 1'b0;
    else clk_prev_q <= stage_q[STAGES-1][0];
  end

  assign data_sync_o = stage_q[STAGES-1][TW-1:1];
  assign clk_rise_o  = stage_q[STAGES-1][0] & ~clk_prev_q;
  assign clk_fall_o  = ~stage_q[STAGES-1][0] & clk_prev_q;
endmodule

// File: rtl/ssu_regs.sv
module ssu_regs
  import ssu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              flag_i,
  output logic              two_wire_o,
  output clk_sel_e          clk_sel_o,
  output logic              data_we_o,
  output logic              stat_we_o
);
  localparam int PAD_C = DATA_W - 3;
  localparam int PAD_S = DATA_W - 1 - CNT_W;

  logic     two_wire_q;
  clk_sel_e clk_sel_q;
  logic     ctrl_we;

  assign ctrl_we   = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign stat_we_o = reg_wr_i && (reg_addr_i == ADDR_STAT);
  assign data_we_o = reg_wr_i && (reg_addr_i == ADDR_DATA);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      two_wire_q <= 1'b0;
      clk_sel_q  <= CS_OFF;
    end else if (ctrl_we) begin
      two_wire_q <= reg_wdata_i[0];
      clk_sel_q  <= clk_sel_e'(reg_wdata_i[2:1]);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) reg_rdata_o <= '0;
    else begin
      case (reg_addr_i)
        ADDR_CTRL: reg_rdata_o <= {{PAD_C{1'b0}}, clk_sel_q, two_wire_q};
        ADDR_STAT: reg_rdata_o <= {flag_i, {PAD_S{1'b0}}, count_i};
        ADDR_DATA: reg_rdata_o <= data_i;
        default:   reg_rdata_o <= '0;
      endcase
    end
  end

  assign two_wire_o = two_wire_q;
  assign clk_sel_o  = clk_sel_q;
endmodule

// File: rtl/ssu_shift.sv
module ssu_shift
  import ssu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  clk_sel_e          clk_sel_i,
  input  logic              clk_rise_i,
  input  logic              clk_fall_i,
  input  logic              din_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_wdata_i,
  input  logic              stat_we_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic              flag_clr_bit_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              flag_o,
  output logic              flag_clr_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  count_q;
  logic              flag_q;
  logic              edge_en, any_edge, shift_edge;

  assign edge_en    = (clk_sel_i == CS_RISE) || (clk_sel_i == CS_FALL);
  assign any_edge   = edge_en && (clk_rise_i || clk_fall_i);
  assign shift_edge = ((clk_sel_i == CS_RISE) && clk_rise_i) ||
                      ((clk_sel_i == CS_FALL) && clk_fall_i);
  assign flag_clr_o = stat_we_i && flag_clr_bit_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) data_q <= '0;
    else if (data_we_i) data_q <= data_wdata_i;
    else if (shift_edge) data_q <= {data_q[DATA_W-2:0], din_i};
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      count_q <= '0;
      flag_q  <= 1'b0;
    end else if (stat_we_i) begin
      count_q <= cnt_wdata_i;
      if (flag_clr_bit_i) flag_q <= 1'b0;
    end else if (any_edge) begin
      count_q <= count_q + 1'b1;
      if (count_q == CNT_MAX) flag_q <= 1'b1;
    end
  end

  assign data_o  = data_q;
  assign count_o = count_q;
  assign flag_o  = flag_q;

  assert_count_step_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (any_edge && !stat_we_i) |=> (count_q == $past(count_q) + 1'b1));
  assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (flag_q && !flag_clr_o) |=> flag_q);
  assert_wrap_on_set_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(flag_q) |-> (count_q == '0));
endmodule

// File: rtl/ssu_pads.sv
module ssu_pads (
  input  logic clk_i,
  input  logic rst_i,
  input  logic two_wire_i,
  input  logic flag_i,
  input  logic flag_clr_i,
  input  logic clk_fall_i,
  input  logic data_msb_i,
  output logic so_o,
  output logic sda_oe_o,
  output logic scl_oe_o
);
  logic hold_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      so_o     <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      so_o     <= data_msb_i;
      sda_oe_o <= two_wire_i & ~data_msb_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) hold_q <= 1'b0;
    else if (!two_wire_i || flag_clr_i) hold_q <= 1'b0;
    else if (flag_i && clk_fall_i) hold_q <= 1'b1;
  end

  assign scl_oe_o = hold_q;

  assert_hold_needs_flag_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    scl_oe_o |-> flag_i);
  assert_sda_only_2w_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    sda_oe_o |-> $past(two_wire_i));
endmodule

// File: rtl/ssu_top.sv
module ssu_top
  import ssu_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              ser_clk_i,
  input  logic              sdi_i,
  input  logic              sda_i,
  output logic              so_o,
  output logic              sda_oe_o,
  output logic              scl_oe_o
);
  logic [1:0]        pin_sync;
  logic              clk_rise, clk_fall, din;
  logic              two_wire, data_we, stat_we, flag, flag_clr;
  clk_sel_e          clk_sel;
  logic [DATA_W-1:0] data;
  logic [CNT_W-1:0]  count;

  ssu_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .clk_pin_i(ser_clk_i),
    .data_pin_i({sda_i, sdi_i}), .data_sync_o(pin_sync),
    .clk_rise_o(clk_rise), .clk_fall_o(clk_fall));

  assign din = two_wire ? pin_sync[1] : pin_sync[0];

  ssu_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .data_i(data),
    .count_i(count), .flag_i(flag), .two_wire_o(two_wire), .clk_sel_o(clk_sel),
    .data_we_o(data_we), .stat_we_o(stat_we));

  ssu_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk_i(clk_i), .rst_i(rst_i), .clk_sel_i(clk_sel), .clk_rise_i(clk_rise),
    .clk_fall_i(clk_fall), .din_i(din), .data_we_i(data_we),
    .data_wdata_i(reg_wdata_i), .stat_we_i(stat_we),
    .cnt_wdata_i(reg_wdata_i[CNT_W-1:0]), .flag_clr_bit_i(reg_wdata_i[DATA_W-1]),
    .data_o(data), .count_o(count), .flag_o(flag), .flag_clr_o(flag_clr));

  ssu_pads u_pads (
    .clk_i(clk_i), .rst_i(rst_i), .two_wire_i(two_wire), .flag_i(flag),
    .flag_clr_i(flag_clr), .clk_fall_i(clk_fall), .data_msb_i(data[DATA_W-1]),
    .so_o(so_o), .sda_oe_o(sda_oe_o), .scl_oe_o(scl_oe_o));
endmodule

// File: tb/ssu_top_tb_top.sv
module ssu_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ser_clk = 1'b0, sdi = 1'b0, sda = 1'b1;
  logic       so, sda_oe, scl_oe;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_data;
  logic [3:0] m_cnt;
  logic       m_flag, m_hold, m_2w;
  logic [1:0] m_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssu_top dut_i (
    .clk_i(clk), .rst_i(rst), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ser_clk_i(ser_clk),
    .sdi_i(sdi), .sda_i(sda), .so_o(so), .sda_oe_o(sda_oe), .scl_oe_o(scl_oe));

  function automatic logic [7:0] exp_stat();
    return {m_flag, 3'b000, m_cnt};
  endfunction

  function automatic logic exp_sda_oe();
    return m_2w & ~m_data[7];
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      2'd0: begin m_2w = d[0]; m_sel = d[2:1]; if (!d[0]) m_hold = 1'b0; end
      2'd1: begin m_cnt = d[3:0]; if (d[7]) begin m_flag = 1'b0; m_hold = 1'b0; end end
      2'd2: m_data = d;
      default: ;
    endcase
    settle();
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pin_edge(input logic lvl);
    logic rise, fall, din;
    rise = lvl & ~ser_clk;
    fall = ~lvl & ser_clk;
    din  = m_2w ? sda : sdi;
    ser_clk = lvl;
    if (m_2w && m_flag && fall) m_hold = 1'b1;
    if ((m_sel == 2'b01 && rise) || (m_sel == 2'b10 && fall))
      m_data = {m_data[6:0], din};
    if ((m_sel == 2'b01 || m_sel == 2'b10) && (rise || fall)) begin
      if (m_cnt == 4'hF) m_flag = 1'b1;
      m_cnt = m_cnt + 4'd1;
    end
    settle();
  endtask

  task automatic check_pins(input string tag);
    check({tag, " so"}, {7'd0, so}, {7'd0, m_data[7]});
    check({tag, " sda_oe"}, {7'd0, sda_oe}, {7'd0, exp_sda_oe()});
    check({tag, " scl_oe"}, {7'd0, scl_oe}, {7'd0, m_hold});
  endtask

  task automatic check_regs(input string tag);
    logic [7:0] v;
    rd(2'd1, v); check({tag, " status"}, v, exp_stat());
    rd(2'd2, v); check({tag, " data"}, v, m_data);
  endtask

  task automatic transfer(input logic two_w, input logic [1:0] sel,
                          input logic [7:0] tx, input logic [7:0] rx);
    wr(2'd0, 8'h00);
    ser_clk = two_w; sda = 1'b1;
    settle();
    wr(2'd0, {5'd0, sel, two_w});
    wr(2'd2, tx);
    wr(2'd1, 8'h80);
    for (int i = 7; i >= 0; i--) begin
      if (two_w) sda = rx[i]; else sdi = rx[i];
      check_pins("R3 R8 bit");
      pin_edge(~ser_clk);
      pin_edge(~ser_clk);
    end
    check_regs("R5 end of transfer");
    check("R5 received byte", m_data, rx);
    check_pins("R7 R8 after transfer");
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED_1234));
    m_data = '0; m_cnt = '0; m_flag = 0; m_hold = 0; m_2w = 0; m_sel = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 8'h00);
    check_regs("R1");
    check_pins("R1");

    // R2 control readback; R10 one-cycle read latency
    wr(2'd0, 8'hFF);
    rd(2'd0, v); check("R2 ctrl readback", v, 8'h07);
    @(negedge clk); reg_addr = 2'd2;
    @(negedge clk); check("R10 data read after one cycle", reg_rdata, m_data);
    wr(2'd0, 8'h00);

    // R7 data write drives so
    wr(2'd2, 8'h80); check_pins("R7 msb one");
    wr(2'd2, 8'h7F); check_pins("R7 msb zero");

    // R4 disabled source ignores edges
    for (int k = 0; k < 4; k++) pin_edge(~ser_clk);
    check_regs("R4 disabled");

    // R6 count load and flag handling, R5 overflow on wrap
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h8D);
    check_regs("R6 load 13");
    for (int k = 0; k < 3; k++) pin_edge(~ser_clk);
    check_regs("R5 overflow from 13");
    wr(2'd1, 8'h05);
    check_regs("R6 bit7 zero keeps flag");
    wr(2'd1, 8'h80);
    check_regs("R6 clear flag");

    // Directed three-wire and two-wire transfers
    transfer(1'b0, 2'b01, 8'hA5, 8'h3C);
    transfer(1'b1, 2'b10, 8'h0F, 8'hC3);
    // R9 hold on next falling edge, release on clear
    pin_edge(1'b0);
    check_pins("R9 hold after fall with flag");
    check_regs("R9 regs during hold");
    pin_edge(1'b1);
    wr(2'd1, 8'h80);
    check_pins("R9 released by clear");

    // Three-wire never holds
    transfer(1'b0, 2'b10, 8'hFF, 8'h00);
    pin_edge(~ser_clk);
    check_pins("R9 no hold in three-wire");
    wr(2'd1, 8'h80);

    // Random transfers
    for (int t = 0; t < 6; t++) begin
      logic two_w;
      logic [1:0] sel;
      two_w = 1'($urandom % 2);
      sel   = 2'(1 + ($urandom % 2));
      transfer(two_w, sel, 8'($urandom), 8'($urandom));
      pin_edge(~ser_clk);
      check_pins("R9 random post-transfer edge");
      wr(2'd1, 8'h80);
      check_pins("R9 random after clear");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule